// File: doc/BRIEF.md
# Cartridge Bank Mapper

This block is the bank-switch controller of a cartridge port. It watches the processor bus for accesses to the I/O expansion pages (0xDE00–0xDFFF) and, depending on which banking scheme is configured, turns certain reads and writes into new bank numbers. It has two outputs for ROM banks, counted in 8 KB units: one for the lower cartridge window at 0x8000 and one for the upper window. It also drives the two memory-mode lines (game and expansion-ROM select). ROM storage and the decoding of the ROM windows themselves sit outside the block.

The scheme is picked by a 3-bit selector. The block captures this selector only while reset is held, so it stays fixed for the whole session. Each scheme has its own trigger address, its own layout of the bank number within the data or address, its own rule for which values are valid, and in some schemes its own effect on the mode lines. When an access reaches a trigger address but carries a value the scheme rejects, all outputs stay as they were and an error strobe pulses for one cycle.

For schemes that switch 16 KB banks, a bank b is presented as an 8 KB pair: the lower window gets 2b and the upper window gets 2b+1.

Top module: `cart_bank_mapper`

## Requirements
- R1: While reset is held and in the first cycle after it, both bank outputs read 0, game and exrom both read 1, and err reads 0.
- R2: The scheme code is captured only while reset is asserted. Codes: 0 plain, 1 flagged-16K, 2 swizzled-8K, 3 write-window, 4 read-window, 5 disable-capable, 6 validated-16K, 7 mode-16K. A change of the selector after reset has no effect until the next reset.
- R3: Under the plain scheme no access changes any output, and err stays 0.
- R4: Flagged-16K: a write to 0xDFFF with data bit 6 set and data[5:0] ≤ 3 selects 16 KB bank data[1:0]. A write to 0xDFFF with bit 6 clear, or with data[5:0] > 3, is rejected.
- R5: Swizzled-8K: a write to 0xDE00 sets the lower bank to (data[0] << 3) | data[5:3], and the upper bank is left alone. The value 0x86 is rejected.
- R6: Write-window: a write to any address 0xDE00–0xDEFF sets the lower bank to the low address byte. A byte above 63 is rejected.
- R7: Read-window: a read of any address 0xDE00–0xDEFF sets the lower bank to the low address byte, and a byte above 15 is rejected. During that read rd_claim is 1 and rd_data is 0x00. Writes to the page do nothing, and reads outside the page leave rd_claim at 0.
- R8: Disable-capable: a write to 0xDE00 with bit 7 set drives game=1 and exrom=1 and keeps the bank. With bit 7 clear it drives game=1 and exrom=0 and sets the lower bank to data[6:0].
- R9: Validated-16K: a write to 0xDE00 with bit 7 set selects 16 KB bank data[1:0]. A write with bit 7 clear is rejected.
- R10: Mode-16K: a write to 0xDF00 selects 16 KB bank data[1:0]. Data 0x0C drives game=exrom=1, and any other value drives both to 0.
- R11: Register updates and err appear in the cycle after the access. A rejected access raises err for exactly that cycle and leaves both banks, game and exrom unchanged. Accesses that do not hit the scheme's trigger leave everything unchanged with err at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; scheme code captured while high |
| scheme_sel | input | 3 | Banking scheme code |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Processor write data |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| rd_claim | output | 1 | Mapper answers the current read |
| rd_data | output | 8 | Read data while claimed (0x00), 0xFF otherwise |
| lo_bank | output | 7 | 8 KB bank for the lower window |
| hi_bank | output | 7 | 8 KB bank for the upper window |
| game | output | 1 | Game mode line |
| exrom | output | 1 | Expansion-ROM mode line |
| err | output | 1 | One-cycle pulse on a rejected access |

## Verification
The bench goes after the validity edges: bank 3 against bank 4 in the flagged scheme, byte 63 against 64 and 15 against 16 in the window schemes, and the reserved value 0x86. A design that mishandled any of these would either move the bank on a value it must reject, or fail to pulse err. The bit-permuted scheme is driven with values whose bit 0 and bits 5:3 differ, so a design that kept the bits in plain order would show a different bank. A design that sampled the selector after reset would react to a foreign trigger address. In the read-window scheme, a write to the page must not move the bank and a read outside the page must not be claimed.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

    localparam int BANK_W = 7;

    typedef enum logic [2:0] {
        MAP_PLAIN   = 3'd0,
        MAP_FLAG16  = 3'd1,
        MAP_SWIZ8   = 3'd2,
        MAP_WRWIN   = 3'd3,
        MAP_RDWIN   = 3'd4,
        MAP_DISABLE = 3'd5,
        MAP_VALID16 = 3'd6,
        MAP_MODE16  = 3'd7
    } map_kind_e;

    localparam logic [15:0] TRIG_DE00 = 16'hDE00;
    localparam logic [15:0] TRIG_DF00 = 16'hDF00;
    localparam logic [15:0] TRIG_DFFF = 16'hDFFF;
    localparam logic [7:0]  PAGE_DE   = 8'hDE;
    localparam logic [7:0]  SWIZ_RSVD = 8'h86;
    localparam logic [7:0]  MODE_ON   = 8'h0C;
    localparam logic [7:0]  WRWIN_MAX = 8'd63;
    localparam logic [7:0]  RDWIN_MAX = 8'd15;

    typedef struct packed {
        logic       wr_de00;
        logic       wr_df00;
        logic       wr_dfff;
        logic       wr_page;
        logic       rd_page;
        logic [7:0] low8;
    } bus_hits_t;

    typedef struct packed {
        logic              lo_we;
        logic [BANK_W-1:0] lo_val;
        logic              hi_we;
        logic [BANK_W-1:0] hi_val;
        logic              mode_we;
        logic              game;
        logic              exrom;
        logic              bad;
    } map_update_t;

    function automatic logic [BANK_W-1:0] pair_lo(input logic [1:0] b16);
        return {{(BANK_W-3){1'b0}}, b16, 1'b0};
    endfunction

    function automatic logic [BANK_W-1:0] pair_hi(input logic [1:0] b16);
        return {{(BANK_W-3){1'b0}}, b16, 1'b1};
    endfunction

endpackage

// File: rtl/cart_bus_decode.sv
module cart_bus_decode
    import cart_map_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    output bus_hits_t         hits
);
    localparam int PAGE_LSB = ADDR_W - 8;

    logic in_de_page;

    always_comb begin
        in_de_page   = (addr[ADDR_W-1:PAGE_LSB] == PAGE_DE);
        hits.low8    = addr[7:0];
        hits.wr_de00 = we && (addr == TRIG_DE00[ADDR_W-1:0]);
        hits.wr_df00 = we && (addr == TRIG_DF00[ADDR_W-1:0]);
        hits.wr_dfff = we && (addr == TRIG_DFFF[ADDR_W-1:0]);
        hits.wr_page = we && in_de_page;
        hits.rd_page = re && in_de_page;
    end

endmodule

// File: rtl/cart_scheme_decode.sv
module cart_scheme_decode
    import cart_map_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  map_kind_e         kind,
    input  bus_hits_t         hits,
    input  logic [DATA_W-1:0] wdata,
    output map_update_t       upd,
    output logic              claim
);
    logic [7:0] d;

    always_comb begin
        d     = wdata[7:0];
        upd   = '0;
        claim = 1'b0;
        case (kind)
            MAP_FLAG16: begin
                if (hits.wr_dfff) begin
                    if (!d[6] || (d[5:0] > 6'd3)) begin
                        upd.bad = 1'b1;
                    end else begin
                        upd.lo_we  = 1'b1;
                        upd.hi_we  = 1'b1;
                        upd.lo_val = pair_lo(d[1:0]);
                        upd.hi_val = pair_hi(d[1:0]);
                    end
                end
            end
            MAP_SWIZ8: begin
                if (hits.wr_de00) begin
                    if (d == SWIZ_RSVD) begin
                        upd.bad = 1'b1;
                    end else begin
                        upd.lo_we  = 1'b1;
                        upd.lo_val = {{(BANK_W-4){1'b0}}, d[0], d[5:3]};
                    end
                end
            end
            MAP_WRWIN: begin
                if (hits.wr_page) begin
                    if (hits.low8 > WRWIN_MAX) begin
                        upd.bad = 1'b1;
                    end else begin
                        upd.lo_we  = 1'b1;
                        upd.lo_val = hits.low8[BANK_W-1:0];
                    end
                end
            end
            MAP_RDWIN: begin
                claim = hits.rd_page;
                if (hits.rd_page) begin
                    if (hits.low8 > RDWIN_MAX) begin
                        upd.bad = 1'b1;
                    end else begin
                        upd.lo_we  = 1'b1;
                        upd.lo_val = hits.low8[BANK_W-1:0];
                    end
                end
            end
            MAP_DISABLE: begin
                if (hits.wr_de00) begin
                    upd.mode_we = 1'b1;
                    upd.game    = 1'b1;
                    upd.exrom   = d[7];
                    if (!d[7]) begin
                        upd.lo_we  = 1'b1;
                        upd.lo_val = d[6:0];
                    end
                end
            end
            MAP_VALID16: begin
                if (hits.wr_de00) begin
                    if (!d[7]) begin
                        upd.bad = 1'b1;
                    end else begin
                        upd.lo_we  = 1'b1;
                        upd.hi_we  = 1'b1;
                        upd.lo_val = pair_lo(d[1:0]);
                        upd.hi_val = pair_hi(d[1:0]);
                    end
                end
            end
            MAP_MODE16: begin
                if (hits.wr_df00) begin
                    upd.lo_we   = 1'b1;
                    upd.hi_we   = 1'b1;
                    upd.lo_val  = pair_lo(d[1:0]);
                    upd.hi_val  = pair_hi(d[1:0]);
                    upd.mode_we = 1'b1;
                    upd.game    = (d == MODE_ON);
                    upd.exrom   = (d == MODE_ON);
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
    import cart_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  map_kind_e         kind,
    input  map_update_t       upd,
    output logic [BANK_W-1:0] lo_q,
    output logic [BANK_W-1:0] hi_q,
    output logic              game_q,
    output logic              exrom_q,
    output logic              err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q    <= '0;
            hi_q    <= '0;
            game_q  <= 1'b1;
            exrom_q <= 1'b1;
            err_q   <= 1'b0;
        end else begin
            err_q <= upd.bad;
            if (upd.lo_we)   lo_q <= upd.lo_val;
            if (upd.hi_we)   hi_q <= upd.hi_val;
            if (upd.mode_we) begin
                game_q  <= upd.game;
                exrom_q <= upd.exrom;
            end
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (lo_q == '0 && hi_q == '0 && game_q && exrom_q && !err_q)); // R1

    AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (rst)
        err_q |-> ($stable(lo_q) && $stable(hi_q) && $stable(game_q) && $stable(exrom_q))); // R11

    AST_SWIZ_RANGE: assert property (@(posedge clk) disable iff (rst)
        (kind == MAP_SWIZ8) |-> (lo_q < 7'd16)); // R5

    AST_WRWIN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (kind == MAP_WRWIN) |-> (lo_q < 7'd64)); // R6

    AST_RDWIN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (kind == MAP_RDWIN) |-> (lo_q < 7'd16)); // R7

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cart_map_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        scheme_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic              rd_claim,
    output logic [DATA_W-1:0] rd_data,
    output logic [BANK_W-1:0] lo_bank,
    output logic [BANK_W-1:0] hi_bank,
    output logic              game,
    output logic              exrom,
    output logic              err
);
    map_kind_e   kind_q;
    bus_hits_t   hits;
    map_update_t upd;
    logic        claim;

    always_ff @(posedge clk) begin
        if (rst) kind_q <= map_kind_e'(scheme_sel);
    end

    cart_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .we   (bus_we),
        .re   (bus_re),
        .hits (hits)
    );

    cart_scheme_decode #(.DATA_W(DATA_W)) u_sch (
        .kind  (kind_q),
        .hits  (hits),
        .wdata (bus_wdata),
        .upd   (upd),
        .claim (claim)
    );

    cart_bank_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind_q),
        .upd     (upd),
        .lo_q    (lo_bank),
        .hi_q    (hi_bank),
        .game_q  (game),
        .exrom_q (exrom),
        .err_q   (err)
    );

    assign rd_claim = claim;
    assign rd_data  = claim ? '0 : '1;

    AST_KIND_HELD: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(kind_q)); // R2

endmodule

// File: tb/cart_bank_mapper_bench.sv
`timescale 1ns/1ps
module cart_bank_mapper_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  scheme_sel = 3'd0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic        rd_claim;
    logic [7:0]  rd_data;
    logic [6:0]  lo_bank, hi_bank;
    logic        game, exrom, err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        int    lo;
        int    hi;
        bit    g;
        bit    x;
        bit    e;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    cart_bank_mapper u_cart_bank_mapper (
        .clk(clk), .rst(rst), .scheme_sel(scheme_sel),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re),
        .rd_claim(rd_claim), .rd_data(rd_data),
        .lo_bank(lo_bank), .hi_bank(hi_bank),
        .game(game), .exrom(exrom), .err(err)
    );

    // monitor: compares registered outputs one cycle after each access
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            checks++;
            if (lo_bank != it.lo[6:0] || hi_bank != it.hi[6:0] ||
                game != it.g || exrom != it.x || err != it.e) begin
                failures++;
                $display("FAIL %s: got lo=%0d hi=%0d g=%0b x=%0b err=%0b exp lo=%0d hi=%0d g=%0b x=%0b err=%0b",
                         it.tag, lo_bank, hi_bank, game, exrom, err,
                         it.lo, it.hi, it.g, it.x, it.e);
            end
        end
    end

    task automatic do_reset(input logic [2:0] s);
        @(negedge clk);
        rst = 1'b1;
        scheme_sel = s;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;  // R1
        if (lo_bank != 0 || hi_bank != 0 || !game || !exrom || err) begin
            failures++;
            $display("FAIL R1: got lo=%0d hi=%0d g=%0b x=%0b err=%0b exp lo=0 hi=0 g=1 x=1 err=0",
                     lo_bank, hi_bank, game, exrom, err);
        end
    endtask

    task automatic access(input bit w, input bit r, input logic [15:0] a,
                          input logic [7:0] d, input int elo, input int ehi,
                          input bit eg, input bit ex, input bit ee,
                          input bit eclaim, input string tag);
        exp_t it;
        @(negedge clk);
        bus_we = w; bus_re = r; bus_addr = a; bus_wdata = d;
        #1;
        if (r) begin
            checks++;
            if (rd_claim != eclaim || (eclaim && rd_data != 8'h00)) begin
                failures++;
                $display("FAIL %s claim: got claim=%0b data=%02h exp claim=%0b data=00",
                         tag, rd_claim, rd_data, eclaim);
            end
        end
        @(posedge clk);
        it.lo = elo; it.hi = ehi; it.g = eg; it.x = ex; it.e = ee; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R4 flagged-16K
        do_reset(3'd1);
        access(1,0,16'hDFFF,8'h42, 4,5,1,1,0,0,"R4 bank2");
        access(1,0,16'hDFFF,8'h44, 4,5,1,1,1,0,"R4 bank4 rejected");
        access(1,0,16'hDFFF,8'h01, 4,5,1,1,1,0,"R4 flag clear rejected");
        access(1,0,16'hDFFE,8'h43, 4,5,1,1,0,0,"R11 off-trigger quiet");
        // R2 selector change after reset is ignored
        scheme_sel = 3'd2;
        access(1,0,16'hDE00,8'h29, 4,5,1,1,0,0,"R2 foreign trigger");
        access(1,0,16'hDFFF,8'h43, 6,7,1,1,0,0,"R2 still flagged bank3");

        // R5 swizzled-8K
        do_reset(3'd2);
        access(1,0,16'hDE00,8'h29, 13,0,1,1,0,0,"R5 permuted 13");
        access(1,0,16'hDE00,8'h86, 13,0,1,1,1,0,"R5 reserved");
        access(1,0,16'hDE00,8'h30, 6,0,1,1,0,0,"R5 permuted 6");
        access(1,0,16'hDE01,8'h01, 6,0,1,1,0,0,"R11 swiz off-trigger");

        // R6 write window
        do_reset(3'd3);
        access(1,0,16'hDE2A,8'h00, 42,0,1,1,0,0,"R6 bank42");
        access(1,0,16'hDE3F,8'h00, 63,0,1,1,0,0,"R6 bank63");
        access(1,0,16'hDE40,8'h00, 63,0,1,1,1,0,"R6 bank64 rejected");
        access(0,1,16'hDE05,8'h00, 63,0,1,1,0,0,"R6 read ignored");

        // R7 read window
        do_reset(3'd4);
        access(0,1,16'hDE0F,8'h00, 15,0,1,1,0,1,"R7 bank15");
        access(0,1,16'hDE10,8'h00, 15,0,1,1,1,1,"R7 bank16 rejected");
        access(1,0,16'hDE03,8'h00, 15,0,1,1,0,0,"R7 write ignored");
        access(0,1,16'hDF00,8'h00, 15,0,1,1,0,0,"R7 outside page");
        access(0,1,16'hDE02,8'h00, 2,0,1,1,0,1,"R7 bank2");

        // R8 disable-capable
        do_reset(3'd5);
        access(1,0,16'hDE00,8'h15, 21,0,1,0,0,0,"R8 bank21");
        access(1,0,16'hDE00,8'h80, 21,0,1,1,0,0,"R8 disable");
        access(1,0,16'hDE00,8'h7F, 127,0,1,0,0,0,"R8 bank127");

        // R9 validated-16K
        do_reset(3'd6);
        access(1,0,16'hDE00,8'h83, 6,7,1,1,0,0,"R9 bank3");
        access(1,0,16'hDE00,8'h03, 6,7,1,1,1,0,"R9 bit7 clear rejected");
        access(1,0,16'hDE00,8'h81, 2,3,1,1,0,0,"R9 bank1");

        // R10 mode-16K
        do_reset(3'd7);
        access(1,0,16'hDF00,8'h06, 4,5,0,0,0,0,"R10 bank2 mode off");
        access(1,0,16'hDF00,8'h0C, 0,1,1,1,0,0,"R10 0x0C mode on");
        access(1,0,16'hDF00,8'h0D, 2,3,0,0,0,0,"R10 0x0D mode off");

        // R3 plain scheme
        do_reset(3'd0);
        access(1,0,16'hDFFF,8'h42, 0,0,1,1,0,0,"R3 plain write dfff");
        access(1,0,16'hDE00,8'h83, 0,0,1,1,0,0,"R3 plain write de00");
        access(0,1,16'hDE05,8'h00, 0,0,1,1,0,0,"R3 plain read");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule